// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block is the host-side half of an indirect configuration access scheme for a PCI-style host bridge. Software first writes a 32-bit target address into an address window. It then reads or writes a data window, and the bridge turns each data-window access into a configuration transaction on a downstream request/response port. The latched word names the target: bit 31 enables forwarding, bits 23:16 give the bus, bits 15:8 give device/function (slot in 7:3, function in 2:0) and bits 7:0 give the register offset.

Each forwarded access has two downstream phases. A probe phase asks whether the target exists and whether it is exposed. An access phase then carries the byte offset, the clamped length and the write data. Any access that cannot reach a real, exposed register reads as all-ones and leaves the target untouched. Such accesses include a disabled port, a missing device, a hidden function and an offset past the configuration limit.

Top module: `cfg_port_bridge`

## Requirements
- R1: After a synchronous reset the address latch holds zero, so forwarding is disabled. No downstream request and no read-data valid are asserted.
- R2: The address latch takes a new value only from a host write to the address window (`hb_win`=0) with `hb_off`=0 and `hb_len`=4. Every other address-window write leaves it unchanged.
- R3: A host read of the address window returns all 32 latched bits, whatever the offset and length. `hb_rvalid` is high in the cycle after the request.
- R4: While latch bit 31 is 0, data-window writes are discarded and data-window reads return 0xFFFFFFFF. Neither kind starts a downstream request.
- R5: The effective address is the latched word ORed with `hb_off`. The bridge forwards bus = bits 23:16, devfn = bits 15:8 and offset = bits 7:0 of that word.
- R6: If the probe acknowledge reports `ds_present`=0, the access phase is skipped. A read returns 0xFFFFFFFF and a write never reaches the target.
- R7: A target is treated as absent when the probe reports all three of the following: `ds_hotadd`=1, a nonzero function number, and `ds_fn0_present`=0. The same function is served normally when `ds_fn0_present`=1.
- R8: The forwarded length is the smaller of `hb_len` (1 to 4) and `CFG_LIMIT` minus the offset. An offset at or beyond `CFG_LIMIT` is not forwarded, and reads of it return all-ones.
- R9: Read data is right-aligned. Bytes above the forwarded length are returned as zero.
- R10: Every access phase follows a probe of the same target. Each phase holds `ds_req` and all request fields stable until `ds_ack`.
- R11: A forwarded read returns its data with `hb_rvalid` in the cycle after the final acknowledge. `hb_busy` is high from the cycle after the request until that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hb_req | input | 1 | Single-cycle host access request |
| hb_we | input | 1 | 1 = write, 0 = read |
| hb_win | input | 1 | 0 = address window, 1 = data window |
| hb_off | input | 2 | Byte offset of the access within the window |
| hb_len | input | 3 | Access length in bytes, 1 to 4 |
| hb_wdata | input | 32 | Host write data |
| hb_busy | output | 1 | A forwarded access is in progress |
| hb_rvalid | output | 1 | Read data valid pulse |
| hb_rdata | output | 32 | Read data |
| ds_req | output | 1 | Downstream request, held until acknowledge |
| ds_probe | output | 1 | 1 = presence probe phase, 0 = access phase |
| ds_we | output | 1 | Access phase is a write |
| ds_bus | output | 8 | Target bus number |
| ds_devfn | output | 8 | Target device/function |
| ds_off | output | 8 | Register byte offset |
| ds_len | output | 3 | Forwarded length in bytes |
| ds_wdata | output | 32 | Write data |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_present | input | 1 | Target exists (probe acknowledge) |
| ds_hotadd | input | 1 | Target was added after start-up (probe acknowledge) |
| ds_fn0_present | input | 1 | Function 0 of the target slot exists (probe acknowledge) |
| ds_rdata | input | 32 | Read data (access acknowledge) |

## Verification
The hardest situation to reach from the ports is a hidden function. This is a hot-added, nonzero function whose slot has no function 0. The probe admits it only if the bridge combines three sideband flags correctly. The downstream model in the bench derives presence, hot-add state and function-0 presence from the target's slot and function. Latching a target in slot 3 (function 0 absent) or slot 2 (function 0 present) therefore exercises both outcomes of the rule. A non-zero acknowledge latency on the downstream side makes the hold-until-acknowledge rule observable. Offsets near 0xFF drive the length clamp to 1 and 2 bytes.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PROBE  = 2'd1,
    SEQ_ACCESS = 2'd2
  } seq_state_e;

  // Bytes actually forwarded: requested length, capped by room left before the limit.
  function automatic logic [2:0] clamp_len(input logic [7:0] off,
                                           input logic [2:0] len,
                                           input logic [31:0] limit);
    logic [31:0] room;
    room = ({24'd0, off} < limit) ? (limit - {24'd0, off}) : 32'd0;
    return ({29'd0, len} < room) ? len : room[2:0];
  endfunction

  // Keeps the low 'len' bytes of a returned word.
  function automatic logic [31:0] len_mask(input logic [2:0] len);
    case (len)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // A hot-added non-zero function stays invisible until function 0 exists.
  function automatic logic fn_hidden(input logic hot, input logic [2:0] fn,
                                     input logic fn0_here);
    return hot && (fn != 3'd0) && !fn0_here;
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          hb_we,
  input  logic          hb_win,
  input  logic [1:0]    hb_off,
  input  logic [2:0]    hb_len,
  input  logic [AW-1:0] hb_wdata,
  output logic          upd,
  output logic [AW-1:0] latch_q
);
  localparam logic [2:0] FULL_LEN = 3'(AW / 8);

  assign upd = acc && hb_we && !hb_win && (hb_off == 2'd0) && (hb_len == FULL_LEN);

  always_ff @(posedge clk) begin
    if (rst)      latch_q <= '0;
    else if (upd) latch_q <= hb_wdata;
  end
endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode #(
  parameter int AW        = 32,
  parameter int CFG_LIMIT = 256
) (
  input  logic [AW-1:0] latch_q,
  input  logic [1:0]    hb_off,
  input  logic [2:0]    hb_len,
  output logic          enable,
  output logic [7:0]    bus,
  output logic [7:0]    devfn,
  output logic [7:0]    off,
  output logic [2:0]    len,
  output logic          in_range
);
  import cfg_bridge_pkg::*;

  logic [AW-1:0] eff;

  assign eff      = latch_q | {{(AW-2){1'b0}}, hb_off};
  assign enable   = latch_q[AW-1];
  assign bus      = eff[23:16];
  assign devfn    = eff[15:8];
  assign off      = eff[7:0];
  assign in_range = ({24'd0, off} < 32'(CFG_LIMIT));
  assign len      = clamp_len(off, hb_len, 32'(CFG_LIMIT));
endmodule

// File: rtl/cfg_ds_sequencer.sv
module cfg_ds_sequencer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we_in,
  input  logic [7:0]    bus_in,
  input  logic [7:0]    devfn_in,
  input  logic [7:0]    off_in,
  input  logic [2:0]    len_in,
  input  logic [DW-1:0] wdata_in,
  output logic          busy,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          refused,
  output logic          ds_req,
  output logic          ds_probe,
  output logic          ds_we,
  output logic [7:0]    ds_bus,
  output logic [7:0]    ds_devfn,
  output logic [7:0]    ds_off,
  output logic [2:0]    ds_len,
  output logic [DW-1:0] ds_wdata,
  input  logic          ds_ack,
  input  logic          ds_present,
  input  logic          ds_hotadd,
  input  logic          ds_fn0_present,
  input  logic [DW-1:0] ds_rdata
);
  import cfg_bridge_pkg::*;

  seq_state_e    state_q;
  logic          we_q;
  logic [7:0]    bus_q, devfn_q, off_q;
  logic [2:0]    len_q;
  logic [DW-1:0] wdata_q;
  logic          admit;

  assign admit   = ds_present && !fn_hidden(ds_hotadd, devfn_q[2:0], ds_fn0_present);
  assign refused = (state_q == SEQ_PROBE) && ds_ack && !admit;
  assign rd_done = !we_q && ds_ack &&
                   (((state_q == SEQ_PROBE) && !admit) || (state_q == SEQ_ACCESS));
  assign rd_data = (state_q == SEQ_ACCESS) ? (ds_rdata & len_mask(len_q)) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE:   if (start)  state_q <= SEQ_PROBE;
        SEQ_PROBE:  if (ds_ack) state_q <= admit ? SEQ_ACCESS : SEQ_IDLE;
        SEQ_ACCESS: if (ds_ack) state_q <= SEQ_IDLE;
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == SEQ_IDLE && start) begin
      we_q    <= we_in;
      bus_q   <= bus_in;
      devfn_q <= devfn_in;
      off_q   <= off_in;
      len_q   <= len_in;
      wdata_q <= wdata_in;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign ds_req   = busy;
  assign ds_probe = (state_q == SEQ_PROBE);
  assign ds_we    = we_q && (state_q == SEQ_ACCESS);
  assign ds_bus   = bus_q;
  assign ds_devfn = devfn_q;
  assign ds_off   = off_q;
  assign ds_len   = len_q;
  assign ds_wdata = wdata_q;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int CFG_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hb_req,
  input  logic        hb_we,
  input  logic        hb_win,
  input  logic [1:0]  hb_off,
  input  logic [2:0]  hb_len,
  input  logic [31:0] hb_wdata,
  output logic        hb_busy,
  output logic        hb_rvalid,
  output logic [31:0] hb_rdata,
  output logic        ds_req,
  output logic        ds_probe,
  output logic        ds_we,
  output logic [7:0]  ds_bus,
  output logic [7:0]  ds_devfn,
  output logic [7:0]  ds_off,
  output logic [2:0]  ds_len,
  output logic [31:0] ds_wdata,
  input  logic        ds_ack,
  input  logic        ds_present,
  input  logic        ds_hotadd,
  input  logic        ds_fn0_present,
  input  logic [31:0] ds_rdata
);
  localparam int AW = 32;

  logic          acc, addr_upd, addr_rd, dat_acc, fwd_start, quick_ones;
  logic          enable, in_range, seq_busy, seq_rd_done, refused;
  logic [AW-1:0] latch_q, seq_rd_data;
  logic [7:0]    t_bus, t_devfn, t_off;
  logic [2:0]    t_len;

  assign acc        = hb_req && !seq_busy;
  assign addr_rd    = acc && !hb_we && !hb_win;
  assign dat_acc    = acc && hb_win;
  assign fwd_start  = dat_acc && enable && in_range;
  assign quick_ones = dat_acc && !hb_we && !(enable && in_range);

  cfg_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .acc(acc), .hb_we(hb_we), .hb_win(hb_win),
    .hb_off(hb_off), .hb_len(hb_len), .hb_wdata(hb_wdata),
    .upd(addr_upd), .latch_q(latch_q)
  );

  cfg_target_decode #(.AW(AW), .CFG_LIMIT(CFG_LIMIT)) u_decode (
    .latch_q(latch_q), .hb_off(hb_off), .hb_len(hb_len),
    .enable(enable), .bus(t_bus), .devfn(t_devfn), .off(t_off),
    .len(t_len), .in_range(in_range)
  );

  cfg_ds_sequencer #(.DW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(fwd_start), .we_in(hb_we),
    .bus_in(t_bus), .devfn_in(t_devfn), .off_in(t_off), .len_in(t_len),
    .wdata_in(hb_wdata), .busy(seq_busy), .rd_done(seq_rd_done),
    .rd_data(seq_rd_data), .refused(refused),
    .ds_req(ds_req), .ds_probe(ds_probe), .ds_we(ds_we), .ds_bus(ds_bus),
    .ds_devfn(ds_devfn), .ds_off(ds_off), .ds_len(ds_len), .ds_wdata(ds_wdata),
    .ds_ack(ds_ack), .ds_present(ds_present), .ds_hotadd(ds_hotadd),
    .ds_fn0_present(ds_fn0_present), .ds_rdata(ds_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_rvalid <= 1'b0;
      hb_rdata  <= '0;
    end else begin
      hb_rvalid <= addr_rd || quick_ones || seq_rd_done;
      if (addr_rd)         hb_rdata <= latch_q;
      else if (quick_ones) hb_rdata <= '1;
      else if (seq_rd_done) hb_rdata <= seq_rd_data;
    end
  end

  assign hb_busy = seq_busy;
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int CFG_LIMIT = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        hb_req,
  input logic        hb_we,
  input logic        hb_win,
  input logic [1:0]  hb_off,
  input logic [2:0]  hb_len,
  input logic        hb_busy,
  input logic        hb_rvalid,
  input logic [31:0] hb_rdata,
  input logic [31:0] latch_q,
  input logic        refused,
  input logic        ds_req,
  input logic        ds_ack,
  input logic        ds_probe,
  input logic        ds_we,
  input logic [7:0]  ds_bus,
  input logic [7:0]  ds_devfn,
  input logic [7:0]  ds_off,
  input logic [2:0]  ds_len,
  input logic [31:0] ds_wdata
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ds_req && !hb_rvalid && latch_q == 32'd0));

  a_r2_latch_guarded: assert property (@(posedge clk) disable iff (rst)
    !(hb_req && hb_we && !hb_win && hb_off == 2'd0 && hb_len == 3'd4)
      |=> $stable(latch_q));

  a_r3_addr_read: assert property (@(posedge clk) disable iff (rst)
    (hb_req && !hb_we && !hb_win && !hb_busy)
      |=> (hb_rvalid && hb_rdata == $past(latch_q)));

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    (hb_req && hb_win && !latch_q[31] && !hb_busy) |=> !ds_req);

  a_r6_refusal_ends: assert property (@(posedge clk) disable iff (rst)
    refused |=> !ds_req);

  a_r8_len_in_limit: assert property (@(posedge clk) disable iff (rst)
    ds_req |-> (ds_len != 3'd0 && ds_len <= 3'd4 &&
                (32'(ds_off) + 32'(ds_len)) <= 32'(CFG_LIMIT)));

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (ds_req && !ds_ack) |=> (ds_req &&
      $stable({ds_probe, ds_we, ds_bus, ds_devfn, ds_off, ds_len, ds_wdata})));

  a_r11_busy_tracks_req: assert property (@(posedge clk) disable iff (rst)
    ds_req |-> hb_busy);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.CFG_LIMIT(CFG_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .hb_req(hb_req), .hb_we(hb_we), .hb_win(hb_win),
  .hb_off(hb_off), .hb_len(hb_len), .hb_busy(hb_busy), .hb_rvalid(hb_rvalid),
  .hb_rdata(hb_rdata), .latch_q(latch_q), .refused(refused),
  .ds_req(ds_req), .ds_ack(ds_ack), .ds_probe(ds_probe), .ds_we(ds_we),
  .ds_bus(ds_bus), .ds_devfn(ds_devfn), .ds_off(ds_off), .ds_len(ds_len),
  .ds_wdata(ds_wdata)
);

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic        hb_req = 1'b0, hb_we = 1'b0, hb_win = 1'b0;
  logic [1:0]  hb_off = '0;
  logic [2:0]  hb_len = 3'd4;
  logic [31:0] hb_wdata = '0;
  logic        hb_busy, hb_rvalid;
  logic [31:0] hb_rdata;
  logic        ds_req, ds_probe, ds_we;
  logic [7:0]  ds_bus, ds_devfn, ds_off;
  logic [2:0]  ds_len;
  logic [31:0] ds_wdata;
  logic        ds_ack = 1'b0, ds_present = 1'b0, ds_hotadd = 1'b0, ds_fn0_present = 1'b0;
  logic [31:0] ds_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int lat = 0, wcnt = 0;
  int probe_cnt = 0, wr_cnt = 0, seq_err = 0;
  logic [23:0] last_probe = '0;
  logic [7:0]  lw_bus, lw_devfn, lw_off;
  logic [2:0]  lw_len;
  logic [31:0] lw_data;

  always #10 clk = ~clk;

  cfg_port_bridge dut (.*);

  // Downstream model: slots 1..3 of buses 0..1, functions 0..3, slot 3 has no function 0.
  // Functions above 0 in slots 2 and 3 are hot-added. Read data = {5A, bus, devfn, off}.
  function automatic logic m_present(input logic [7:0] b, input logic [7:0] df);
    return (b < 8'd2) && (df[7:3] >= 5'd1) && (df[7:3] <= 5'd3) && (df[2:0] < 3'd4)
           && !(df[7:3] == 5'd3 && df[2:0] == 3'd0);
  endfunction

  always @(negedge clk) begin
    if (ds_req) begin
      if (wcnt == lat) begin
        ds_ack         <= 1'b1;
        ds_present     <= m_present(ds_bus, ds_devfn);
        ds_hotadd      <= (ds_devfn[7:3] >= 5'd2) && (ds_devfn[2:0] != 3'd0);
        ds_fn0_present <= (ds_devfn[7:3] != 5'd3);
        ds_rdata       <= {8'h5A, ds_bus, ds_devfn, ds_off};
        wcnt           <= 0;
        if (ds_probe) begin
          probe_cnt  <= probe_cnt + 1;
          last_probe <= {ds_bus, ds_devfn, ds_off};
        end else begin
          if ({ds_bus, ds_devfn, ds_off} != last_probe) seq_err <= seq_err + 1;
          if (ds_we) begin
            wr_cnt <= wr_cnt + 1;
            lw_bus <= ds_bus; lw_devfn <= ds_devfn; lw_off <= ds_off;
            lw_len <= ds_len; lw_data <= ds_wdata;
          end
        end
      end else begin
        ds_ack <= 1'b0;
        wcnt   <= wcnt + 1;
      end
    end else begin
      ds_ack <= 1'b0;
      wcnt   <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic win, input logic we, input logic [1:0] off,
                         input logic [2:0] len, input logic [31:0] wd,
                         output logic [31:0] rd, output logic got);
    int guard;
    @(negedge clk);
    hb_req = 1'b1; hb_win = win; hb_we = we; hb_off = off; hb_len = len; hb_wdata = wd;
    @(negedge clk);
    hb_req = 1'b0;
    guard = 0;
    while (hb_busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    got = hb_rvalid;
    rd  = hb_rdata;
  endtask

  // {req id, we, win, off, len, wdata, expected read}
  localparam int NV = 22;
  localparam logic [74:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 2'd0, 3'd4, 32'h0,         32'h0000_0000}, // R1 latch zero
    {4'd2,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8000_0810, 32'h0},
    {4'd3,  1'b0, 1'b0, 2'd2, 3'd1, 32'h0,         32'h8000_0810}, // R3 full word
    {4'd2,  1'b1, 1'b0, 2'd1, 3'd4, 32'h1234_5678, 32'h0},         // R2 bad offset
    {4'd2,  1'b1, 1'b0, 2'd0, 3'd2, 32'hDEAD_BEEF, 32'h0},         // R2 bad length
    {4'd2,  1'b0, 1'b0, 2'd3, 3'd2, 32'h0,         32'h8000_0810}, // R2 unchanged
    {4'd5,  1'b0, 1'b1, 2'd0, 3'd4, 32'h0,         32'h5A00_0810}, // R5 decode
    {4'd9,  1'b0, 1'b1, 2'd3, 3'd1, 32'h0,         32'h0000_0013}, // R9 byte
    {4'd9,  1'b0, 1'b1, 2'd2, 3'd2, 32'h0,         32'h0000_0812}, // R9 half
    {4'd9,  1'b0, 1'b1, 2'd1, 3'd3, 32'h0,         32'h0000_0811}, // R9 three bytes
    {4'd4,  1'b1, 1'b0, 2'd0, 3'd4, 32'h0000_0810, 32'h0},
    {4'd4,  1'b0, 1'b1, 2'd0, 3'd4, 32'h0,         32'hFFFF_FFFF}, // R4 disabled
    {4'd7,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8001_1A00, 32'h0},
    {4'd7,  1'b0, 1'b1, 2'd0, 3'd4, 32'h0,         32'hFFFF_FFFF}, // R7 hidden
    {4'd7,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8001_1200, 32'h0},
    {4'd7,  1'b0, 1'b1, 2'd0, 3'd4, 32'h0,         32'h5A01_1200}, // R7 exposed
    {4'd6,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8002_0800, 32'h0},
    {4'd6,  1'b0, 1'b1, 2'd0, 3'd4, 32'h0,         32'hFFFF_FFFF}, // R6 absent
    {4'd8,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8000_08FC, 32'h0},
    {4'd8,  1'b0, 1'b1, 2'd2, 3'd4, 32'h0,         32'h0000_08FE}, // R8 clamp 2
    {4'd8,  1'b0, 1'b1, 2'd3, 3'd4, 32'h0,         32'h0000_00FF}, // R8 clamp 1
    {4'd5,  1'b1, 1'b0, 2'd0, 3'd4, 32'h8001_0B04, 32'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        got;
    int          pc, wc;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 ds_req after reset", {31'd0, ds_req}, 32'd0);
    check("R1 rvalid after reset", {31'd0, hb_rvalid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i][69], VEC[i][70], VEC[i][68:67], VEC[i][66:64], VEC[i][63:32], rd, got);
      if (!VEC[i][70]) begin
        check($sformatf("R%0d vec %0d rvalid", VEC[i][74:71], i), {31'd0, got}, 32'd1);
        check($sformatf("R%0d vec %0d data", VEC[i][74:71], i), rd, VEC[i][31:0]);
      end
    end

    // R5: latched bus 1 / devfn 0B / off 04, low bits of data offset ORed in
    host_op(1'b1, 1'b0, 2'd1, 3'd4, 32'h0, rd, got);
    check("R5 merged offset read", rd, 32'h5A01_0B05);
    host_op(1'b1, 1'b1, 2'd2, 3'd2, 32'h0000_BEEF, rd, got);
    check("R5 write bus", {24'd0, lw_bus}, 32'h01);
    check("R5 write devfn", {24'd0, lw_devfn}, 32'h0B);
    check("R5 write offset", {24'd0, lw_off}, 32'h06);
    check("R5 write length", {29'd0, lw_len}, 32'd2);
    check("R5 write data", lw_data, 32'h0000_BEEF);

    // R8: write at offset FF forwards a single byte
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_08FC, rd, got);
    wc = wr_cnt;
    host_op(1'b1, 1'b1, 2'd3, 3'd4, 32'hCAFE_F00D, rd, got);
    check("R8 clamped write count", wr_cnt, wc + 1);
    check("R8 clamped write length", {29'd0, lw_len}, 32'd1);
    check("R8 clamped write offset", {24'd0, lw_off}, 32'hFF);

    // R4: disabled port issues nothing downstream
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h0000_0810, rd, got);
    pc = probe_cnt; wc = wr_cnt;
    host_op(1'b1, 1'b1, 2'd0, 3'd4, 32'h1111_1111, rd, got);
    host_op(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, got);
    check("R4 disabled read data", rd, 32'hFFFF_FFFF);
    check("R4 no probe while disabled", probe_cnt, pc);
    check("R4 no write while disabled", wr_cnt, wc);

    // R6: absent target, write never reaches it
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h8002_0800, rd, got);
    pc = probe_cnt; wc = wr_cnt;
    host_op(1'b1, 1'b1, 2'd0, 3'd4, 32'h2222_2222, rd, got);
    check("R6 probe issued", probe_cnt, pc + 1);
    check("R6 write dropped", wr_cnt, wc);

    // R7: hidden hot-added function drops writes
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h8001_1A00, rd, got);
    wc = wr_cnt;
    host_op(1'b1, 1'b1, 2'd0, 3'd4, 32'h3333_3333, rd, got);
    check("R7 hidden write dropped", wr_cnt, wc);

    // R10 / R11: slow downstream, request held, data returned after last acknowledge
    lat = 3;
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_1008, rd, got);
    host_op(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, got);
    check("R11 slow read valid", {31'd0, got}, 32'd1);
    check("R10 slow read data", rd, 32'h5A00_1008);
    check("R10 probe precedes access", seq_err, 0);
    lat = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule